// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox with Retry

This block takes interrupt messages arriving from an external bus and parks each one in a mailbox slot belonging to the CPU it targets. A message names a target CPU and a source id, and carries two 64-bit data words. Every CPU owns exactly one slot. A slot holds a busy flag, the source id and both data words.

When the target slot is free, the message is accepted in the same cycle it is presented. The slot is filled and marked busy. One cycle later the block posts an interrupt to that CPU, using a single vector that software programs and that all CPUs share. When the slot is still busy, the block answers with retry and changes nothing. The sender must offer the message again later. Software releases a slot by writing its busy flag to zero.

Software reaches the slots in two ways. It can use indexed addresses with an 8-byte stride, in one region each for data word 0, data word 1 and the busy/source word. It can also use three alias addresses that select the slot of the CPU making the request.

Top module: `cpu_irq_mailbox`

## Requirements
- R1: After reset, every busy flag and the shared vector are zero. `post_valid`, `msg_accept` and `reg_rvalid` are low.
- R2: A message (`msg_valid` high) for a CPU whose slot is free is accepted. In the same cycle `msg_accept` is high and `msg_retry` is low. At the next clock edge the slot stores the source id and both data words, and its busy flag is set.
- R3: A message for a CPU whose slot is busy is refused. In the same cycle `msg_retry` is high and `msg_accept` is low. The slot's busy flag, source id and data words are left unchanged.
- R4: Each accepted message produces exactly one post, on the cycle after acceptance. `post_cpu` is the target CPU, and `post_vec` is the shared vector as it stood in the cycle of acceptance. No post occurs without an acceptance.
- R5: A write to byte address 0x318 loads the shared vector from `reg_wdata[5:0]`. A read of 0x318 returns the vector zero-extended.
- R6: A busy/source word reads with the busy flag in bit 5, the source id in bits 4:0 and zero in every other bit. A write to a busy/source word loads the busy flag from bit 5 only. The source id is not changed by such a write.
- R7: The indexed slots for CPU i are at 0x000+8*i (data word 0), 0x100+8*i (data word 1) and 0x200+8*i (busy/source). A read returns its data with `reg_rvalid` high in the cycle after `reg_rd`.
- R8: The aliases 0x300 (data word 0), 0x308 (data word 1) and 0x310 (busy/source) act on the slot selected by `reg_req_cpu`.
- R9: If a write that clears a slot's busy flag and a message for that slot occur in the same cycle, the clear takes effect first and the message is accepted. If the write sets busy in the same cycle, the message is refused.
- R10: Writes to the data-word regions are ignored. Reads of unused addresses in the 0x300 region return zero.

Ports are in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Incoming message present |
| msg_cpu | input | 5 | Target CPU of the message |
| msg_src | input | 5 | Source id of the message |
| msg_data0 | input | 64 | Message data word 0 |
| msg_data1 | input | 64 | Message data word 1 |
| msg_accept | output | 1 | Message taken this cycle |
| msg_retry | output | 1 | Message refused; the sender must retry |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | 5 | CPU receiving the post |
| post_vec | output | 6 | Vector posted |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register byte address |
| reg_req_cpu | input | 5 | Id of the requesting CPU, used by the aliases |
| reg_wdata | input | 64 | Register write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 64 | Read data |

## Verification
Messages are sent to a free slot, to a busy slot, and to the lowest and highest CPU numbers. A free slot must store the message, while a busy one must retry and keep its old contents. The CPU-number cases show whether the index decode reaches both ends of the array.

The bench also collides a busy clear and a busy set with an arriving message for the same CPU in the same cycle. These two cases tell apart the two possible priorities between software and the bus. Alias reads issued from the owning CPU and from a foreign CPU show whether the alias takes the requester's id rather than a fixed slot.

A scoreboard compares each post against the target and the vector that were current when the message was accepted.

// File: rtl/cim_pkg.sv
package cim_pkg;
  // bit position of the busy flag in a busy/source word
  localparam int BUSY_BIT = 5;
  // sub-slot selector inside the alias/control region
  localparam int ALIAS_D0   = 0;
  localparam int ALIAS_D1   = 1;
  localparam int ALIAS_BUSY = 2;
  localparam int ALIAS_VEC  = 3;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_D0   = 3'd1,
    SEL_D1   = 3'd2,
    SEL_BUSY = 3'd3,
    SEL_VEC  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/cim_addr_dec.sv
module cim_addr_dec
  import cim_pkg::*;
#(
  parameter int CPU_N  = 32,
  parameter int IDX_W  = $clog2(CPU_N),
  parameter int ADDR_W = IDX_W + 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  req_cpu,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int REG_LSB = IDX_W + 3;
  localparam logic [IDX_W:0] CPU_LIM = CPU_N[IDX_W:0];

  logic [1:0]       region;
  logic [IDX_W-1:0] slot;
  logic             slot_ok;
  logic [1:0]       sub;
  logic             sub_ok;

  always_comb begin
    region  = addr[REG_LSB+1:REG_LSB];
    slot    = addr[REG_LSB-1:3];
    slot_ok = ({1'b0, slot} < CPU_LIM);
    sub     = addr[4:3];
    sub_ok  = (addr[REG_LSB-1:5] == '0);
    sel     = SEL_NONE;
    idx     = slot;
    unique case (region)
      2'd0: if (slot_ok) sel = SEL_D0;
      2'd1: if (slot_ok) sel = SEL_D1;
      2'd2: if (slot_ok) sel = SEL_BUSY;
      default: begin
        idx = req_cpu;
        if (sub_ok) begin
          unique case (sub)
            2'(ALIAS_D0):   sel = SEL_D0;
            2'(ALIAS_D1):   sel = SEL_D1;
            2'(ALIAS_BUSY): sel = SEL_BUSY;
            default:        sel = SEL_VEC;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/cim_entry.sv
module cim_entry #(
  parameter int SRC_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              sw_we,
  input  logic              sw_busy,
  input  logic [SRC_W-1:0]  src_in,
  input  logic [DATA_W-1:0] d0_in,
  input  logic [DATA_W-1:0] d1_in,
  output logic              busy_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [DATA_W-1:0] d0_q,
  output logic [DATA_W-1:0] d1_q
);
  logic busy_d;

  // an accepted message outranks the software write (the top only
  // accepts when the write leaves the slot free)
  always_comb begin
    busy_d = busy_q;
    if (sw_we) busy_d = sw_busy;
    if (load)  busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else if (load) begin
      src_q <= src_in;
      d0_q  <= d0_in;
      d1_q  <= d1_in;
    end
  end
endmodule

// File: rtl/cim_post.sv
module cim_post #(
  parameter int IDX_W = 5,
  parameter int VEC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] cpu_in,
  input  logic [VEC_W-1:0] vec_in,
  output logic             post_valid,
  output logic [IDX_W-1:0] post_cpu,
  output logic [VEC_W-1:0] post_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) post_valid <= 1'b0;
    else        post_valid <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cpu <= '0;
      post_vec <= '0;
    end else if (fire) begin
      post_cpu <= cpu_in;
      post_vec <= vec_in;
    end
  end
endmodule

// File: rtl/cpu_irq_mailbox.sv
module cpu_irq_mailbox
  import cim_pkg::*;
#(
  parameter int CPU_N  = 32,
  parameter int SRC_W  = 5,
  parameter int DATA_W = 64,
  parameter int VEC_W  = 6,
  localparam int IDX_W  = $clog2(CPU_N),
  localparam int ADDR_W = IDX_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [IDX_W-1:0]  msg_cpu,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [DATA_W-1:0] msg_data0,
  input  logic [DATA_W-1:0] msg_data1,
  output logic              msg_accept,
  output logic              msg_retry,
  output logic              post_valid,
  output logic [IDX_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [IDX_W-1:0]  reg_req_cpu,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [IDX_W:0] CPU_LIM = CPU_N[IDX_W:0];

  reg_sel_e          dec_sel;
  logic [IDX_W-1:0]  dec_idx;
  logic              wr_busy;
  logic              wr_vec;
  logic              busy_eff;
  logic              cpu_ok;
  logic [VEC_W-1:0]  vec_q;
  logic [VEC_W-1:0]  vec_d;
  logic [DATA_W-1:0] rd_mux;
  logic              rvalid_d;

  logic              busy_a [CPU_N];
  logic [SRC_W-1:0]  src_a  [CPU_N];
  logic [DATA_W-1:0] d0_a   [CPU_N];
  logic [DATA_W-1:0] d1_a   [CPU_N];

  cim_addr_dec #(.CPU_N(CPU_N), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .addr    (reg_addr),
    .req_cpu (reg_req_cpu),
    .sel     (dec_sel),
    .idx     (dec_idx)
  );

  always_comb begin
    wr_busy = reg_wr && (dec_sel == SEL_BUSY);
    wr_vec  = reg_wr && (dec_sel == SEL_VEC);
    cpu_ok  = ({1'b0, msg_cpu} < CPU_LIM);
    // a same-cycle software write to the target slot decides its state first
    if (wr_busy && (dec_idx == msg_cpu))
      busy_eff = reg_wdata[BUSY_BIT];
    else
      busy_eff = busy_a[msg_cpu];
    msg_accept = msg_valid && cpu_ok && !busy_eff;
    msg_retry  = msg_valid && !msg_accept;
  end

  for (genvar i = 0; i < CPU_N; i++) begin : g_slot
    cim_entry #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (msg_accept && (msg_cpu == IDX_W'(i))),
      .sw_we   (wr_busy && (dec_idx == IDX_W'(i))),
      .sw_busy (reg_wdata[BUSY_BIT]),
      .src_in  (msg_src),
      .d0_in   (msg_data0),
      .d1_in   (msg_data1),
      .busy_q  (busy_a[i]),
      .src_q   (src_a[i]),
      .d0_q    (d0_a[i]),
      .d1_q    (d1_a[i])
    );
  end

  cim_post #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_post (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (msg_accept),
    .cpu_in     (msg_cpu),
    .vec_in     (vec_q),
    .post_valid (post_valid),
    .post_cpu   (post_cpu),
    .post_vec   (post_vec)
  );

  // shared vector register
  always_comb begin
    vec_d = vec_q;
    if (wr_vec) vec_d = reg_wdata[VEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_d;
  end

  // read path
  always_comb begin
    rd_mux = '0;
    unique case (dec_sel)
      SEL_D0:   rd_mux = d0_a[dec_idx];
      SEL_D1:   rd_mux = d1_a[dec_idx];
      SEL_BUSY: begin
        rd_mux[BUSY_BIT]  = busy_a[dec_idx];
        rd_mux[SRC_W-1:0] = src_a[dec_idx];
      end
      SEL_VEC:  rd_mux[VEC_W-1:0] = vec_q;
      default:  rd_mux = '0;
    endcase
    rvalid_d = reg_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rvalid <= 1'b0;
    else        reg_rvalid <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/cpu_irq_mailbox_chk.sv
module cpu_irq_mailbox_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [IDX_W-1:0] msg_cpu,
  input logic             msg_accept,
  input logic             msg_retry,
  input logic             post_valid,
  input logic [IDX_W-1:0] post_cpu,
  input logic             reg_rd,
  input logic             reg_rvalid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!post_valid && !reg_rvalid));

  // R2
  answer_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $onehot({msg_accept, msg_retry}));

  // R3
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> (!msg_accept && !msg_retry));

  // R3
  retry_no_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_retry |=> !post_valid);

  // R4
  post_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_accept |=> (post_valid && post_cpu == $past(msg_cpu)));

  // R4
  post_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> $past(msg_accept));

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R7
  rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> $past(reg_rd));
endmodule

bind cpu_irq_mailbox cpu_irq_mailbox_chk #(.IDX_W(IDX_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_cpu    (msg_cpu),
  .msg_accept (msg_accept),
  .msg_retry  (msg_retry),
  .post_valid (post_valid),
  .post_cpu   (post_cpu),
  .reg_rd     (reg_rd),
  .reg_rvalid (reg_rvalid)
);

// File: tb/test_cpu_irq_mailbox.sv
`timescale 1ns/1ps
module test_cpu_irq_mailbox;
  logic        clk;
  logic        rst_n;
  logic        msg_valid;
  logic [4:0]  msg_cpu;
  logic [4:0]  msg_src;
  logic [63:0] msg_data0;
  logic [63:0] msg_data1;
  logic        msg_accept;
  logic        msg_retry;
  logic        post_valid;
  logic [4:0]  post_cpu;
  logic [5:0]  post_vec;
  logic        reg_wr;
  logic        reg_rd;
  logic [9:0]  reg_addr;
  logic [4:0]  reg_req_cpu;
  logic [63:0] reg_wdata;
  logic        reg_rvalid;
  logic [63:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  logic [5:0]  vec_model = '0;
  logic [10:0] exp_q [$];
  logic [63:0] rd_val;

  cpu_irq_mailbox i_cpu_irq_mailbox (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected post per observed post
  always @(negedge clk) begin
    if (rst_n && post_valid) begin
      if (exp_q.size() == 0) chk("R4 unexpected post", {53'd0, post_vec, post_cpu}, 64'h7FF);
      else chk("R4 post cpu/vec", {53'd0, post_vec, post_cpu}, {53'd0, exp_q.pop_front()});
    end
  end

  task automatic send(input logic [4:0] cpu, input logic [4:0] src, input logic [63:0] d0,
                      input logic [63:0] d1, input logic exp_acc, input string tag);
    @(negedge clk);
    msg_valid = 1'b1; msg_cpu = cpu; msg_src = src; msg_data0 = d0; msg_data1 = d1;
    #1;
    chk(tag, {62'd0, msg_accept, msg_retry}, {62'd0, exp_acc, !exp_acc});
    if (exp_acc) exp_q.push_back({vec_model, cpu});
    @(posedge clk); #1;
    msg_valid = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [63:0] d, input logic [4:0] rc);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_req_cpu = rc;
    if (a == 10'h318) vec_model = d[5:0];
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [4:0] rc, input logic [63:0] exp,
                    input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_req_cpu = rc;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    chk({tag, " rvalid"}, {63'd0, reg_rvalid}, 64'd1);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_valid = 0; msg_cpu = 0; msg_src = 0; msg_data0 = 0; msg_data1 = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_req_cpu = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post_valid", {63'd0, post_valid}, 64'd0);
    chk("R1 rvalid", {63'd0, reg_rvalid}, 64'd0);
    rd(10'h200, 0, 64'h0, "R1 busy0");
    rd(10'h318, 0, 64'h0, "R1 vector");

    wr(10'h318, 64'hFFFF_FFFF_FFFF_FFEA, 0);
    rd(10'h318, 0, 64'h2A, "R5 vector");

    send(5'd3, 5'h11, 64'hA0A0_0000_1111_2222, 64'hB0B0_3333_4444_5555, 1'b1, "R2 accept free");
    rd(10'h018, 0, 64'hA0A0_0000_1111_2222, "R7 data0 idx3");
    rd(10'h118, 0, 64'hB0B0_3333_4444_5555, "R7 data1 idx3");
    rd(10'h218, 0, 64'h31, "R6 busy word idx3");

    send(5'd3, 5'h05, 64'h1, 64'h2, 1'b0, "R3 retry busy");
    rd(10'h018, 0, 64'hA0A0_0000_1111_2222, "R3 data0 kept");
    rd(10'h218, 0, 64'h31, "R3 busy word kept");

    rd(10'h300, 5'd3, 64'hA0A0_0000_1111_2222, "R8 alias data0");
    rd(10'h308, 5'd3, 64'hB0B0_3333_4444_5555, "R8 alias data1");
    rd(10'h310, 5'd3, 64'h31, "R8 alias busy");
    rd(10'h310, 5'd4, 64'h0, "R8 alias other cpu");

    wr(10'h018, 64'hDEAD, 0);
    rd(10'h018, 0, 64'hA0A0_0000_1111_2222, "R10 data write ignored");
    rd(10'h338, 0, 64'h0, "R10 unused read");

    wr(10'h218, 64'hFFFF_FFFF_FFFF_FFDF, 0);
    rd(10'h218, 0, 64'h11, "R6 clear keeps source");

    wr(10'h318, 64'h05, 0);
    send(5'd3, 5'h07, 64'h7, 64'h8, 1'b1, "R2 accept after clear");
    rd(10'h218, 0, 64'h27, "R2 busy word new src");

    // R9: clear via alias in the same cycle as a message
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'h310; reg_req_cpu = 5'd3; reg_wdata = 64'h0;
    msg_valid = 1'b1; msg_cpu = 5'd3; msg_src = 5'h09; msg_data0 = 64'h99; msg_data1 = 64'h98;
    #1;
    chk("R9 clear+msg accept", {63'd0, msg_accept}, 64'd1);
    if (msg_accept) exp_q.push_back({vec_model, 5'd3});
    @(posedge clk); #1;
    reg_wr = 1'b0; msg_valid = 1'b0;
    rd(10'h218, 0, 64'h29, "R9 busy after collision");

    // R9: set in the same cycle as a message
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'h238; reg_wdata = 64'h20;
    msg_valid = 1'b1; msg_cpu = 5'd7; msg_src = 5'h0C;
    #1;
    chk("R9 set+msg retry", {62'd0, msg_accept, msg_retry}, 64'd1);
    @(posedge clk); #1;
    reg_wr = 1'b0; msg_valid = 1'b0;
    rd(10'h238, 0, 64'h20, "R9 busy set src untouched");

    send(5'd31, 5'h1F, 64'hFFFF, 64'hEEEE, 1'b1, "R2 top cpu");
    rd(10'h2F8, 0, 64'h3F, "R7 busy idx31");
    rd(10'h1F8, 0, 64'hEEEE, "R7 data1 idx31");
    send(5'd0, 5'h01, 64'h10, 64'h20, 1'b1, "R2 cpu0");
    rd(10'h000, 0, 64'h10, "R7 data0 idx0");

    repeat (3) @(negedge clk);
    chk("R4 all posts seen", 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule